// File: doc/BRIEF.md
# Secondary Interrupt Gatherer with Direct Routing

This block collects 32 level-sensitive interrupt requests and reduces them to a single request line for an upstream interrupt controller. Each request passes through a per-bit enable mask before the reduction. Bit 0 of the request vector also carries a software-raised interrupt, which is ORed with hardware input 0.

A window of inputs, 21 through 30, can also reach the upstream controller directly. Each line in that window has a direct-route enable bit. When that bit is set, a same-numbered output follows the raw input level, whatever the enable mask holds. The direct-route enables are separate from the enable mask.

Software reaches the block through a simple 32-bit register port. The port decodes word offsets inside a 4 KB window. Reads are combinational, and a write takes effect on the clock edge where it is presented. Both the combined output and the direct outputs are registered, so each reflects the state of the previous cycle.

Top module: `irq_gather_ctrl`

## Requirements
- R1: After reset, irq_out and every direct_out bit are low. Word 2 (enable), word 8 (direct-route enable) and word 4 (software bit) all read zero while irq_in is zero.
- R2: irq_out is 1 in the cycle after any bit of (raw level AND enable mask) is 1, and 0 in the cycle after none is. The raw level is irq_in, with the software bit ORed into bit 0.
- R3: A read of word 0 returns raw level AND enable mask. A read of word 1 returns the raw level. A read of word 2 returns the enable mask.
- R4: A write to word 2 ORs the written value into the enable mask. A write to word 3 clears each mask bit that is 1 in the written value.
- R5: A write to word 8 ORs in only bits 21..30 of the written value (value AND 0x7FE00000). A read of word 8 returns the direct-route enable.
- R6: For i in 21..30 with direct-route enable set, direct_out[i] equals raw level bit i one cycle later, regardless of the enable mask.
- R7: A write to word 9 clears each direct-route enable bit that is 1 in the written value. A line whose direct-route enable is clear drives low, and direct_out bits outside 21..30 are always low.
- R8: Writing a nonzero value to word 4 sets the software bit, and writing a nonzero value to word 5 clears it. A zero write to either word changes nothing. The software bit is ORed into raw level bit 0.
- R9: A read of word 4 returns raw level bit 0 in bit 0, with bits 31..1 zero.
- R10: Reads of write-only words (3, 5, 9) and of undecoded words (6, 7, 10..1023) return zero. Writes to undecoded words change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when no read) |
| irq_out | output | 1 | Combined masked request to the upstream controller |
| direct_out | output | 32 | Direct-routed requests, only bits 21..30 active |

## Verification
A corrupted enable mask shows up on irq_out one cycle after the first raw request it wrongly admits or blocks. It also shows up at once on a read of word 0 or word 2. A wrong direct-route enable changes direct_out one cycle later and is visible at once through word 8. A stuck software bit appears immediately in word 1 and word 4 reads, and on irq_out one cycle later when mask bit 0 is set. The checks therefore pair every state-changing write with a register read-back and a registered-output check on the next cycle.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

  localparam int unsigned IRQG_W = 32;

  // Word offsets decoded inside the register window
  localparam logic [3:0] OFS_MSTAT = 4'd0;
  localparam logic [3:0] OFS_RAW   = 4'd1;
  localparam logic [3:0] OFS_ENSET = 4'd2;
  localparam logic [3:0] OFS_ENCLR = 4'd3;
  localparam logic [3:0] OFS_SWSET = 4'd4;
  localparam logic [3:0] OFS_SWCLR = 4'd5;
  localparam logic [3:0] OFS_DRSET = 4'd8;
  localparam logic [3:0] OFS_DRCLR = 4'd9;

  function automatic logic [IRQG_W-1:0] route_window(int unsigned lo, int unsigned hi);
    logic [IRQG_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < IRQG_W; b++) begin
      if (b >= lo && b <= hi) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irqg_rst_sync.sv
module irqg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irqg_regs.sv
module irqg_regs
  import irqg_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 12,
  parameter logic [IRQG_W-1:0] DR_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [IRQG_W-1:0] bus_wdata,
  output logic [IRQG_W-1:0] bus_rdata,
  input  logic [IRQG_W-1:0] raw_lvl,
  output logic [IRQG_W-1:0] en_mask,
  output logic              swi,
  output logic [IRQG_W-1:0] dr_en
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [3:0]        ofs;
  logic              low_hit;
  logic              wr_go;
  logic              rd_go;
  logic              unused_byte_bits;

  assign word             = bus_addr[ADDR_W-1:2];
  assign ofs              = word[3:0];
  assign low_hit          = (word[WORD_W-1:4] == '0);
  assign wr_go            = bus_sel & bus_wr & low_hit;
  assign rd_go            = bus_sel & ~bus_wr & low_hit;
  assign unused_byte_bits = ^bus_addr[1:0];

  // Enable mask
  logic              en_ce;
  logic [IRQG_W-1:0] en_d, en_q;

  always_comb begin
    en_ce = wr_go & ((ofs == OFS_ENSET) | (ofs == OFS_ENCLR));
    if (ofs == OFS_ENSET) en_d = en_q | bus_wdata;
    else                  en_d = en_q & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  // Software interrupt bit
  logic sw_ce, sw_d, sw_q;

  always_comb begin
    sw_ce = wr_go & ((ofs == OFS_SWSET) | (ofs == OFS_SWCLR)) & (|bus_wdata);
    sw_d  = (ofs == OFS_SWSET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw_q <= 1'b0;
    else if (sw_ce) sw_q <= sw_d;
  end

  // Direct-route enable, only window bits are writable
  logic              dr_ce;
  logic [IRQG_W-1:0] dr_d, dr_q;

  always_comb begin
    dr_ce = wr_go & ((ofs == OFS_DRSET) | (ofs == OFS_DRCLR));
    if (ofs == OFS_DRSET) dr_d = dr_q | (bus_wdata & DR_MASK);
    else                  dr_d = dr_q & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dr_q <= '0;
    else if (dr_ce) dr_q <= dr_d;
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      case (ofs)
        OFS_MSTAT: bus_rdata = raw_lvl & en_q;
        OFS_RAW:   bus_rdata = raw_lvl;
        OFS_ENSET: bus_rdata = en_q;
        OFS_SWSET: bus_rdata = {{(IRQG_W-1){1'b0}}, raw_lvl[0]};
        OFS_DRSET: bus_rdata = dr_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign en_mask = en_q;
  assign swi     = sw_q;
  assign dr_en   = dr_q;

endmodule

// File: rtl/irqg_route.sv
module irqg_route
  import irqg_pkg::*;
#(
  parameter int unsigned DR_LO = 21,
  parameter int unsigned DR_HI = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQG_W-1:0] raw_lvl,
  input  logic [IRQG_W-1:0] en_mask,
  input  logic [IRQG_W-1:0] dr_en,
  output logic              irq_out,
  output logic [IRQG_W-1:0] direct_out
);

  localparam logic [IRQG_W-1:0] DR_MASK = route_window(DR_LO, DR_HI);

  logic unused_dr;
  assign unused_dr = ^(dr_en & ~DR_MASK);

  // Masked OR reduction, registered
  logic comb_d, comb_q, comb_ce;

  always_comb begin
    comb_d  = |(raw_lvl & en_mask);
    comb_ce = (comb_d != comb_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       comb_q <= 1'b0;
    else if (comb_ce) comb_q <= comb_d;
  end

  assign irq_out = comb_q;

  // Per-line direct routing inside the window
  for (genvar i = 0; i < IRQG_W; i++) begin : g_line
    if (i >= DR_LO && i <= DR_HI) begin : g_route
      logic line_d, line_q, line_ce;

      always_comb begin
        line_d  = raw_lvl[i] & dr_en[i];
        line_ce = (line_d != line_q);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       line_q <= 1'b0;
        else if (line_ce) line_q <= line_d;
      end

      assign direct_out[i] = line_q;
    end else begin : g_tie
      assign direct_out[i] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
  import irqg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DR_LO  = 21,
  parameter int unsigned DR_HI  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQG_W-1:0] irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [IRQG_W-1:0] bus_wdata,
  output logic [IRQG_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic [IRQG_W-1:0] direct_out
);

  localparam logic [IRQG_W-1:0] DR_MASK = route_window(DR_LO, DR_HI);

  logic              rst_sync_n;
  logic [IRQG_W-1:0] raw_lvl;
  logic [IRQG_W-1:0] en_mask;
  logic [IRQG_W-1:0] dr_en;
  logic              swi;

  irqg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign raw_lvl = irq_in | {{(IRQG_W-1){1'b0}}, swi};

  irqg_regs #(.ADDR_W(ADDR_W), .DR_MASK(DR_MASK)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .raw_lvl   (raw_lvl),
    .en_mask   (en_mask),
    .swi       (swi),
    .dr_en     (dr_en)
  );

  irqg_route #(.DR_LO(DR_LO), .DR_HI(DR_HI)) u_route (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .raw_lvl    (raw_lvl),
    .en_mask    (en_mask),
    .dr_en      (dr_en),
    .irq_out    (irq_out),
    .direct_out (direct_out)
  );

endmodule

// File: rtl/irqg_sva.sv
module irqg_sva
  import irqg_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 12,
  parameter logic [IRQG_W-1:0] DR_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [IRQG_W-1:0] bus_wdata,
  input logic [IRQG_W-1:0] raw_lvl,
  input logic [IRQG_W-1:0] en_mask,
  input logic [IRQG_W-1:0] dr_en,
  input logic              swi,
  input logic              irq_out,
  input logic [IRQG_W-1:0] direct_out
);

  logic [ADDR_W-3:0] w;
  logic              wr_any;
  logic              wr_known;

  assign w        = bus_addr[ADDR_W-1:2];
  assign wr_any   = bus_sel & bus_wr;
  assign wr_known = (w == 2) || (w == 3) || (w == 4) || (w == 5) || (w == 8) || (w == 9);

  // R2: combined output follows the masked reduction one cycle later
  assert_comb_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_lvl & en_mask)) |=> irq_out);
  assert_comb_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(raw_lvl & en_mask)) |=> !irq_out);

  // R4: clear write removes every addressed mask bit
  assert_enclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && w == 3) |=> ((en_mask & $past(bus_wdata)) == '0));

  // R5: direct-route enable never holds bits outside the window
  assert_dr_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dr_en & ~DR_MASK) == '0));

  // R6: an enabled, raised window line shows up on the direct outputs
  assert_dr_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_lvl & dr_en) != '0) |=> (direct_out != '0));

  // R7: lines without a direct-route enable stay low
  assert_dr_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((direct_out & ~$past(dr_en)) == '0));

  // R8: zero writes to the software registers leave the bit alone
  assert_swi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && (w == 4 || w == 5) && bus_wdata == '0) |=> $stable(swi));

  // R10: writes outside the decoded offsets change no state
  assert_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !wr_known) |=> ($stable(en_mask) && $stable(dr_en) && $stable(swi)));

endmodule

bind irq_gather_ctrl irqg_sva #(.ADDR_W(ADDR_W), .DR_MASK(DR_MASK)) u_sva (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .raw_lvl    (raw_lvl),
  .en_mask    (en_mask),
  .dr_en      (dr_en),
  .swi        (swi),
  .irq_out    (irq_out),
  .direct_out (direct_out)
);

// File: tb/irq_gather_ctrl_tb.sv
`timescale 1ns/1ps
module irq_gather_ctrl_tb;

  localparam int KIND_IRQ = 0;
  localparam int KIND_DIR = 1;
  localparam int KIND_RD  = 2;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic [31:0] direct_out;

  sb_item_t sb_q[$];
  int n_chk;
  int n_err;
  bit done;

  irq_gather_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_out    (irq_out),
    .direct_out (direct_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Monitor: compare queued expectations after the falling edge
  always begin
    @(negedge clk);
    #1;
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        KIND_IRQ: act = {31'b0, irq_out};
        KIND_DIR: act = direct_out;
        default:  act = bus_rdata;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    it.kind = KIND_RD; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    #2;
    bus_sel = 1'b0;
  endtask

  task automatic expect_out(input int kind, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(posedge clk);
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    #2;
  endtask

  task automatic set_irq(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; irq_in = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expect_out(KIND_IRQ, 32'h0, "R1 irq_out");
    expect_out(KIND_DIR, 32'h0, "R1 direct_out");
    expect_rd(12'h008, 32'h0, "R1 enable");
    expect_rd(12'h020, 32'h0, "R1 route enable");
    expect_rd(12'h010, 32'h0, "R1 software bit");

    // R3 raw and masked status with mask clear
    set_irq(32'h4060_0F0A);
    expect_rd(12'h004, 32'h4060_0F0A, "R3 raw");
    expect_rd(12'h000, 32'h0, "R3 masked");
    expect_out(KIND_IRQ, 32'h0, "R2 masked off");

    // R4 enable set
    bus_write(12'h008, 32'h0000_0100);
    expect_rd(12'h008, 32'h0000_0100, "R4 set");
    expect_rd(12'h000, 32'h0000_0100, "R3 masked");
    expect_out(KIND_IRQ, 32'h1, "R2 raised");
    bus_write(12'h008, 32'h8000_0001);
    expect_rd(12'h008, 32'h8000_0101, "R4 set accumulate");
    bus_write(12'h00C, 32'h0000_0100);
    expect_rd(12'h008, 32'h8000_0001, "R4 clear");
    expect_rd(12'h000, 32'h0, "R3 masked after clear");
    expect_out(KIND_IRQ, 32'h0, "R2 dropped");

    // R8 / R9 software interrupt
    bus_write(12'h010, 32'h0000_0005);
    expect_rd(12'h010, 32'h1, "R9 bit only");
    expect_rd(12'h004, 32'h4060_0F0B, "R8 ored into raw");
    expect_out(KIND_IRQ, 32'h1, "R8 via mask bit0");
    bus_write(12'h010, 32'h0);
    bus_write(12'h014, 32'h0);
    expect_rd(12'h010, 32'h1, "R8 zero write ignored");
    bus_write(12'h014, 32'h0000_0080);
    expect_rd(12'h010, 32'h0, "R8 cleared");
    expect_out(KIND_IRQ, 32'h0, "R2 after swi clear");

    // R5 / R6 direct routing
    bus_write(12'h020, 32'hFFFF_FFFF);
    expect_rd(12'h020, 32'h7FE0_0000, "R5 window only");
    expect_out(KIND_DIR, 32'h4060_0000, "R6 follow raw");
    set_irq(32'h9AA1_0004);
    expect_out(KIND_DIR, 32'h1AA0_0000, "R6 new pattern");

    // R7 direct-route clear
    bus_write(12'h024, 32'h1020_0000);
    expect_rd(12'h020, 32'h6FC0_0000, "R7 clear");
    expect_out(KIND_DIR, 32'h0A80_0000, "R7 disabled lines low");

    // R10 undecoded and write-only words
    expect_rd(12'h00C, 32'h0, "R10 word3 read");
    expect_rd(12'h024, 32'h0, "R10 word9 read");
    expect_rd(12'h018, 32'h0, "R10 word6 read");
    expect_rd(12'hFFC, 32'h0, "R10 top word read");
    bus_write(12'h01C, 32'hFFFF_FFFF);
    bus_write(12'h028, 32'hFFFF_FFFF);
    bus_write(12'hFFC, 32'hFFFF_FFFF);
    expect_rd(12'h008, 32'h8000_0001, "R10 enable unchanged");
    expect_rd(12'h020, 32'h6FC0_0000, "R10 route unchanged");
    expect_rd(12'h010, 32'h0, "R10 software unchanged");
    expect_out(KIND_DIR, 32'h0A80_0000, "R10 outputs unchanged");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule